// File: doc/BRIEF.md
# Skewed Signature Dead-Block Predictor

This block guesses whether a cache line has seen its last use. The guess is based on the history of instruction addresses that have touched the line. For every line, the cache controller stores a 15-bit running signature and one prediction bit. The predictor itself stores neither. It acts as an update-and-lookup engine that is driven by three kinds of event. A **fill** starts a fresh signature. An **access** trains the predictor toward "still live" and then extends the signature. An **evict** trains the predictor toward "dead" for the signature the line had when it left.

Learning is held in two banks of 2-bit saturating counters. Each bank is indexed by a different hash of the signature. Adding the two counter values gives a confidence figure, which is compared against a threshold parameter. Two unrelated signatures can collide in one bank, but they rarely collide in both, so one bad collision is diluted by the other bank. For fills and accesses, the block returns the new signature and the dead/live verdict one clock after the event. One event is accepted per clock. Each event sees every counter change made by the events before it, including the event in the cycle just before.

Top module: `deadblk_predictor`

## Requirements
- R1: Synchronous reset (active high) clears every counter in both banks to 0 and drives `rsp_valid` low. With the default threshold of 4, a probe after reset reports live (`rsp_dead` = 0).
- R2: The event code is `ev_kind` = 0 idle, 1 fill, 2 access, 3 evict. A fill ignores `ev_sig`. It returns the signature 0 + fold(PC) and changes no counter.
- R3: fold(PC) is `ev_pc[14:0]` XOR `ev_pc[29:15]`. PC bits above 29 have no effect. The signature update is a 15-bit add that wraps modulo 2^15.
- R4: An access first decrements, in each bank, the counter selected by the incoming (old) signature. It then forms the new signature as old + fold(PC). The verdict is read with the new signature and already reflects the decrement.
- R5: An evict increments, in each bank, the counter selected by `ev_sig`. It produces no response: `rsp_valid` is low in the following cycle.
- R6: Counters saturate at 3 on increment and at 0 on decrement.
- R7: The verdict is dead when (bank A counter + bank B counter) ≥ `THRESH`. The default `THRESH` is 4, and `THRESH` may range from 0 to 6. `rsp_dead` is 0 whenever `rsp_valid` is 0.
- R8: Bank A uses hash sig[13:0] XOR {sig[14], 13'b0}. Bank B uses hash ({sig[7:0], sig[14:8]})[13:0] XOR 14'h2A5B. Each bank indexes with the low `IDX_W` bits of its hash (default 8).
- R9: An event in one cycle sees the counter updates made by the event in the immediately preceding cycle.
- R10: Fills and accesses raise `rsp_valid`, together with `rsp_sig` and `rsp_dead`, exactly one cycle after the event. Idle cycles and evicts give `rsp_valid` = 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_kind | input | 2 | Event code: 0 idle, 1 fill, 2 access, 3 evict |
| ev_sig | input | 15 | The line's stored signature (access, evict) |
| ev_pc | input | PC_W | Instruction address (fill, access) |
| rsp_valid | output | 1 | Response present for the previous cycle's fill or access |
| rsp_sig | output | 15 | Updated signature to store with the line |
| rsp_dead | output | 1 | Dead verdict to store with the line |

## Verification
The bench drives a counter model built from the requirements. It pays closest attention to the cases a subtly wrong design would miss. Back-to-back events on the same counter catch a design that reads stale counters, because its verdict would lag by one event. Saturation runs past both ends catch counters that wrap, which would flip a strongly dead entry to live. Two signatures that share a bank-A index but not a bank-B index expose a design that sums the wrong bank or reuses one hash for both banks. Confidence sums of exactly 3 and exactly 4 catch an off-by-one in the threshold compare. Accesses whose new signature equals the old one catch a verdict that was read before the decrement. A wrapping add and PC bits above bit 29 catch a fold or adder of the wrong width.

// File: rtl/dbp_pkg.sv
package dbp_pkg;

    localparam int SIG_W   = 15;
    localparam int HASH_W  = 14;
    localparam int CTR_W   = 2;
    localparam int FOLD_W  = 30;

    typedef logic [SIG_W-1:0]  sig_t;
    typedef logic [HASH_W-1:0] hash_t;
    typedef logic [CTR_W-1:0]  ctr_t;

    typedef enum logic [1:0] {
        EV_IDLE   = 2'd0,
        EV_FILL   = 2'd1,
        EV_ACCESS = 2'd2,
        EV_EVICT  = 2'd3
    } ev_kind_e;

    typedef struct packed {
        logic valid;
        sig_t sig;
        logic dead;
    } rsp_t;

    // Fold 30 address bits down to a signature-sized term.
    function automatic sig_t pc_fold(input logic [FOLD_W-1:0] pc);
        return pc[14:0] ^ pc[29:15];
    endfunction

    // Bank A index hash: fold the top bit onto bit 13.
    function automatic hash_t hash_a(input sig_t s);
        return s[13:0] ^ {s[14], 13'b0};
    endfunction

    // Bank B index hash: rotate by seven, then scramble with a constant.
    function automatic hash_t hash_b(input sig_t s);
        sig_t r;
        r = {s[7:0], s[14:8]};
        return r[13:0] ^ 14'h2A5B;
    endfunction

    // One saturating step of a 2-bit counter.
    function automatic ctr_t ctr_step(input ctr_t v, input logic up);
        if (up)
            return (v == 2'd3) ? v : v + 2'd1;
        else
            return (v == 2'd0) ? v : v - 2'd1;
    endfunction

endpackage

// File: rtl/dbp_sig_next.sv
module dbp_sig_next
    import dbp_pkg::*;
(
    input  ev_kind_e           kind,
    input  sig_t               old_sig,
    input  logic [FOLD_W-1:0]  pc,
    output sig_t               new_sig
);
    sig_t base;

    always_comb begin
        base    = (kind == EV_FILL) ? '0 : old_sig;
        new_sig = base + pc_fold(pc);
    end
endmodule

// File: rtl/dbp_ctr_bank.sv
module dbp_ctr_bank
    import dbp_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int HASH_SEL = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic upd_en,
    input  logic upd_up,
    input  sig_t upd_sig,
    input  sig_t rd_sig,
    output ctr_t rd_val
);
    localparam int DEPTH = 1 << IDX_W;

    ctr_t              ctr [DEPTH];
    hash_t             upd_h;
    hash_t             rd_h;
    logic [IDX_W-1:0]  upd_idx;
    logic [IDX_W-1:0]  rd_idx;
    ctr_t              upd_nxt;

    generate
        if (HASH_SEL == 0) begin : g_hash_a
            always_comb begin
                upd_h = hash_a(upd_sig);
                rd_h  = hash_a(rd_sig);
            end
        end else begin : g_hash_b
            always_comb begin
                upd_h = hash_b(upd_sig);
                rd_h  = hash_b(rd_sig);
            end
        end
    endgenerate

    always_comb begin
        upd_idx = upd_h[IDX_W-1:0];
        rd_idx  = rd_h[IDX_W-1:0];
        upd_nxt = ctr_step(ctr[upd_idx], upd_up);
        // A read of the entry being written this cycle sees the written value.
        if (upd_en && (rd_idx == upd_idx))
            rd_val = upd_nxt;
        else
            rd_val = ctr[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                ctr[i] <= '0;
        end else if (upd_en) begin
            ctr[upd_idx] <= upd_nxt;
        end
    end
endmodule

// File: rtl/deadblk_predictor.sv
module deadblk_predictor
    import dbp_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 8,
    parameter int THRESH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        ev_kind,
    input  logic [14:0]       ev_sig,
    input  logic [PC_W-1:0]   ev_pc,
    output logic              rsp_valid,
    output logic [14:0]       rsp_sig,
    output logic              rsp_dead
);
    localparam int   NBANK = 2;
    localparam int   CONF_W = CTR_W + 1;
    localparam logic [CONF_W-1:0] THR = CONF_W'(THRESH);

    ev_kind_e           kind;
    sig_t               nxt_sig;
    logic               upd_en;
    logic               upd_up;
    logic               want_rsp;
    ctr_t               bank_val [NBANK];
    logic [CONF_W-1:0]  conf;
    rsp_t               rsp_q;
    rsp_t               rsp_d;

    assign kind     = ev_kind_e'(ev_kind);
    assign upd_en   = (kind == EV_ACCESS) || (kind == EV_EVICT);
    assign upd_up   = (kind == EV_EVICT);
    assign want_rsp = (kind == EV_FILL) || (kind == EV_ACCESS);

    dbp_sig_next u_sig (
        .kind    (kind),
        .old_sig (ev_sig),
        .pc      (ev_pc[FOLD_W-1:0]),
        .new_sig (nxt_sig)
    );

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            dbp_ctr_bank #(
                .IDX_W    (IDX_W),
                .HASH_SEL (b)
            ) u_bank (
                .clk     (clk),
                .rst     (rst),
                .upd_en  (upd_en),
                .upd_up  (upd_up),
                .upd_sig (ev_sig),
                .rd_sig  (nxt_sig),
                .rd_val  (bank_val[b])
            );
        end
    endgenerate

    always_comb begin
        conf = '0;
        for (int b = 0; b < NBANK; b++)
            conf = conf + CONF_W'(bank_val[b]);
        rsp_d.valid = want_rsp;
        rsp_d.sig   = want_rsp ? nxt_sig : '0;
        rsp_d.dead  = want_rsp && (conf >= THR);
    end

    always_ff @(posedge clk) begin
        if (rst)
            rsp_q <= '0;
        else
            rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_sig   = rsp_q.sig;
    assign rsp_dead  = rsp_q.dead;
endmodule

// File: rtl/deadblk_predictor_chk.sv
module deadblk_predictor_chk
    import dbp_pkg::*;
#(
    parameter int PC_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       ev_kind,
    input logic [14:0]      ev_sig,
    input logic [PC_W-1:0]  ev_pc,
    input logic             rsp_valid,
    input logic [14:0]      rsp_sig,
    input logic             rsp_dead
);
    // R1: a reset cycle leaves no response behind it.
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !rsp_valid);

    // R10: fills and accesses answer on the next cycle.
    a_r10_rsp_next_cycle: assert property (@(posedge clk) disable iff (rst)
        (ev_kind == 2'd1 || ev_kind == 2'd2) |=> rsp_valid);

    // R5 / R10: evicts and idle cycles give no response.
    a_r5_evict_silent: assert property (@(posedge clk) disable iff (rst)
        (ev_kind == 2'd3 || ev_kind == 2'd0) |=> !rsp_valid);

    // R2: a fill restarts the signature from the folded PC.
    a_r2_fill_sig: assert property (@(posedge clk) disable iff (rst)
        (ev_kind == 2'd1) |=> rsp_sig == pc_fold($past(ev_pc[29:0])));

    // R3: an access extends the stored signature with a wrapping add.
    a_r3_access_sig: assert property (@(posedge clk) disable iff (rst)
        (ev_kind == 2'd2) |=>
            rsp_sig == 15'($past(ev_sig) + pc_fold($past(ev_pc[29:0]))));

    // R7: no dead verdict without a valid response.
    a_r7_dead_needs_valid: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !rsp_dead);
endmodule

bind deadblk_predictor deadblk_predictor_chk #(.PC_W(PC_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .ev_kind   (ev_kind),
    .ev_sig    (ev_sig),
    .ev_pc     (ev_pc),
    .rsp_valid (rsp_valid),
    .rsp_sig   (rsp_sig),
    .rsp_dead  (rsp_dead)
);

// File: tb/deadblk_predictor_tb_top.sv
module deadblk_predictor_tb_top;
    localparam int PC_W   = 32;
    localparam int IDX_W  = 8;
    localparam int THRESH = 4;
    localparam int DEPTH  = 1 << IDX_W;
    localparam int NVEC   = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        ev_kind = 2'd0;
    logic [14:0]       ev_sig = '0;
    logic [PC_W-1:0]   ev_pc = '0;
    logic              rsp_valid;
    logic [14:0]       rsp_sig;
    logic              rsp_dead;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    deadblk_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .THRESH(THRESH)) dut_i (
        .clk(clk), .rst(rst), .ev_kind(ev_kind), .ev_sig(ev_sig), .ev_pc(ev_pc),
        .rsp_valid(rsp_valid), .rsp_sig(rsp_sig), .rsp_dead(rsp_dead)
    );

    // Reference counters, built from the requirements.
    int ma [DEPTH];
    int mb [DEPTH];

    function automatic logic [14:0] m_fold(input logic [31:0] pc);
        return pc[14:0] ^ pc[29:15];
    endfunction
    function automatic int m_ia(input logic [14:0] s);
        logic [13:0] h;
        h = s[13:0] ^ {s[14], 13'b0};
        return int'(h[IDX_W-1:0]);
    endfunction
    function automatic int m_ib(input logic [14:0] s);
        logic [14:0] r;
        logic [13:0] h;
        r = {s[7:0], s[14:8]};
        h = r[13:0] ^ 14'h2A5B;
        return int'(h[IDX_W-1:0]);
    endfunction

    // Expectation for the event applied in the previous cycle.
    bit          pend_valid = 0;
    logic [14:0] pend_sig   = '0;
    bit          pend_dead  = 0;
    string       pend_tag   = "R1";

    task automatic check_pending();
        checks++;
        if (rsp_valid !== pend_valid ||
            (pend_valid && (rsp_sig !== pend_sig || rsp_dead !== pend_dead))) begin
            fails++;
            $display("FAIL %s: got valid=%0b sig=%h dead=%0b, expected valid=%0b sig=%h dead=%0b",
                     pend_tag, rsp_valid, rsp_sig, rsp_dead, pend_valid, pend_sig, pend_dead);
        end
    endtask

    task automatic ev(input logic [1:0] k, input logic [14:0] s,
                      input logic [31:0] pc, input string tag);
        logic [14:0] ns;
        int ia, ib;
        @(negedge clk);
        check_pending();
        ev_kind = k; ev_sig = s; ev_pc = pc;
        pend_tag = tag;
        if (k == 2'd3) begin
            ia = m_ia(s); ib = m_ib(s);
            if (ma[ia] < 3) ma[ia]++;
            if (mb[ib] < 3) mb[ib]++;
            pend_valid = 0;
        end else if (k == 2'd0) begin
            pend_valid = 0;
        end else begin
            if (k == 2'd2) begin
                ia = m_ia(s); ib = m_ib(s);
                if (ma[ia] > 0) ma[ia]--;
                if (mb[ib] > 0) mb[ib]--;
                ns = s + m_fold(pc);
            end else begin
                ns = m_fold(pc);
            end
            pend_valid = 1;
            pend_sig   = ns;
            pend_dead  = (ma[m_ia(ns)] + mb[m_ib(ns)]) >= THRESH;
        end
    endtask

    // kind, signature, pc
    localparam logic [48:0] VEC [NVEC] = '{
        {2'd1, 15'h0000, 32'h0000_1234},
        {2'd2, 15'h1234, 32'h0000_0040},
        {2'd3, 15'h1274, 32'h0000_0000},
        {2'd3, 15'h1274, 32'h0000_0000},
        {2'd1, 15'h0000, 32'h0000_1274},
        {2'd2, 15'h1274, 32'h0001_8000},
        {2'd3, 15'h1275, 32'h0000_0000},
        {2'd0, 15'h0000, 32'h0000_0000},
        {2'd1, 15'h7ABC, 32'h1234_5678},
        {2'd2, 15'h2222, 32'h0BAD_F00D},
        {2'd3, 15'h2222, 32'h0000_0000},
        {2'd3, 15'h2222, 32'h0000_0000},
        {2'd3, 15'h2222, 32'h0000_0000},
        {2'd1, 15'h0000, 32'h0000_2222},
        {2'd2, 15'h2222, 32'h0000_0000},
        {2'd2, 15'h2222, 32'h0000_0000}
    };

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin ma[i] = 0; mb[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: no response straight after reset; counters read zero.
        pend_valid = 0; pend_tag = "R1 reset";
        ev(2'd1, 15'h0000, 32'h0000_0000, "R1 probe after reset");

        // Table walk: fills, accesses, evicts, idles (R2 R3 R4 R5 R9 R10).
        for (int v = 0; v < NVEC; v++)
            ev(VEC[v][48:47], VEC[v][46:32], VEC[v][31:0], "R2/R4/R5 table");

        // R6: saturate upward, sum 6 -> dead.
        for (int n = 0; n < 5; n++)
            ev(2'd3, 15'h0123, 32'h0, "R6 evict");
        ev(2'd1, 15'h0000, 32'h0000_0123, "R6 saturate high probe");
        // R4 / R7: access keeping signature reads after decrement: sum 4 dead, then 2 live.
        ev(2'd2, 15'h0123, 32'h0, "R4 R7 sum four");
        ev(2'd2, 15'h0123, 32'h0, "R7 sum two");
        for (int n = 0; n < 4; n++)
            ev(2'd2, 15'h0123, 32'h0, "R6 saturate low");
        // R9: evict then immediate probe of the same entry.
        ev(2'd3, 15'h0123, 32'h0, "R9 evict");
        ev(2'd1, 15'h0000, 32'h0000_0123, "R9 forwarding sum two");
        ev(2'd3, 15'h0123, 32'h0, "R9 evict");
        ev(2'd1, 15'h0000, 32'h0000_0123, "R9 forwarding sum four");

        // R8: shared bank-A index, different bank-B index -> sum 3, live.
        for (int n = 0; n < 3; n++)
            ev(2'd3, 15'h0042, 32'h0, "R8 evict");
        ev(2'd1, 15'h0000, 32'h0000_0142, "R8 alias probe");
        ev(2'd1, 15'h0000, 32'h0000_0042, "R8 own probe");

        // R3: wrapping add and ignored PC bits 31:30.
        ev(2'd2, 15'h7FFF, 32'hC000_0001, "R3 wrap");
        ev(2'd0, 15'h0000, 32'h0, "R10 idle");
        ev(2'd0, 15'h0000, 32'h0, "R10 flush");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule